// File: doc/BRIEF.md
# Pattern Write-Readback Memory Tester

This engine checks a window of memory by filling it with a fixed set of alternating bit patterns and reading every word back. A calibration controller pulses `start` with a base word address. The engine writes 64 words of 32 bits to consecutive addresses starting at that base. Only after all 64 writes are acknowledged does it begin reading, and it reads each word ten times in a row before moving on to the next one.

Every read is compared with the word that was written. The first read that differs ends the run with a fail. The run passes only if all 640 reads match. The result appears as a one-cycle `done` pulse. The `pass` flag is valid in that same cycle and stays unchanged until the next accepted `start`.

The memory side uses a simple request/acknowledge handshake. A single write or read request is held until it is acknowledged. The request then drops for at least one cycle before the next one is issued.

Top module: `mem_pattern_checker`

## Requirements
- R1: While reset is high and in the first cycle after it, `done`, `pass`, `mem_we` and `mem_re` are all 0.
- R2: An accepted run issues exactly 64 writes, word i going to address (base + i) modulo 2^ADDR_W, in ascending order. No read is issued before the 64th write has been acknowledged.
- R3: Write data for word i (0..63) is built from group g = i/16, with group words 0x00000000, 0xAAAAAAAA, 0xA5A5A5A5, 0xAA55AA55 for g = 0..3. Word i is the bitwise inverse of its group word when bit (i mod 16) of 16'h33CC is 1, and the group word itself otherwise.
- R4: Only one of `mem_we` and `mem_re` is high at a time. A raised request keeps its address and write data unchanged until the cycle in which `mem_ack` is high. The request is low in the cycle after that acknowledge.
- R5: Reads go to the same addresses as the writes, in ascending word order, with read number n (0..639) addressing word n/10.
- R6: The first read whose `mem_rdata` differs from the expected word causes `done` to be 1 in the cycle after its acknowledge, with `pass` = 0. No further request is issued.
- R7: If all 640 reads match, `done` is 1 in the cycle after the last read acknowledge, with `pass` = 1.
- R8: `done` is high for exactly one cycle per run. `pass` changes only in a `done` cycle or in the cycle after an accepted `start`, which clears it to 0.
- R9: A `start` pulse while a run is in progress is ignored. The run continues with its original base, and only one `done` results.
- R10: The base address is captured when `start` is accepted. Later changes on `base_addr` do not affect the addresses of that run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a run (accepted only when idle) |
| base_addr | input | ADDR_W | First word address of the test window |
| done | output | 1 | One-cycle end-of-run pulse |
| pass | output | 1 | Run result, held until next accepted start |
| mem_addr | output | ADDR_W | Word address of the current request |
| mem_wdata | output | 32 | Write data |
| mem_we | output | 1 | Write request |
| mem_re | output | 1 | Read request |
| mem_rdata | input | 32 | Read data, valid with acknowledge |
| mem_ack | input | 1 | Acknowledge of the current request |

## Verification
Clean runs with acknowledge latencies of 0 to 3 cycles, including a base that wraps the address space, show that the pattern and address sequence are independent of handshake timing. Read faults injected on the first read, on the last of all 640 reads, and on a read in the middle of a ten-read burst pin down how many reads the engine makes before stopping, which separates an early abort from a late one. A bit stuck in one written word shows that every word is actually compared rather than only the last one. A second `start` together with a changed base during a run shows that the captured base is kept.

// File: rtl/mpt_pkg.sv
package mpt_pkg;

  localparam int WORD_W  = 32;
  localparam int PAT_LEN = 64;

  typedef logic [WORD_W-1:0] word_t;

  typedef enum logic [2:0] {
    ST_IDLE     = 3'd0,
    ST_WR_ISSUE = 3'd1,
    ST_WR_WAIT  = 3'd2,
    ST_RD_ISSUE = 3'd3,
    ST_RD_WAIT  = 3'd4
  } mpt_state_e;

  // Group base word selected by index bits [5:4]
  function automatic word_t group_word(input logic [1:0] grp);
    case (grp)
      2'd0:    return 32'h0000_0000;
      2'd1:    return 32'hAAAA_AAAA;
      2'd2:    return 32'hA5A5_A5A5;
      default: return 32'hAA55_AA55;
    endcase
  endfunction

  // Pairs are numbered by bits [3:1]; pairs 1,3,4,6 are inverted
  function automatic word_t pattern_word(input logic [5:0] idx);
    logic inv;
    inv = idx[1] ^ idx[3];
    return group_word(idx[5:4]) ^ {WORD_W{inv}};
  endfunction

endpackage

// File: rtl/mpt_counter.sv
module mpt_counter #(
  parameter int LIMIT = 64,
  localparam int W = (LIMIT > 1) ? $clog2(LIMIT) : 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] val,
  output logic         at_last
);

  assign at_last = (val == W'(LIMIT - 1));

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      val <= '0;
    end else if (inc) begin
      val <= at_last ? '0 : val + W'(1);
    end
  end

endmodule

// File: rtl/mpt_pattern_gen.sv
module mpt_pattern_gen
  import mpt_pkg::*;
#(
  parameter int IDX_W = 6
) (
  input  logic [IDX_W-1:0] idx,
  output word_t            pat
);

  logic [5:0] idx6;

  generate
    if (IDX_W >= 6) begin : g_trim
      assign idx6 = idx[5:0];
    end else begin : g_pad
      assign idx6 = {{(6 - IDX_W){1'b0}}, idx};
    end
  endgenerate

  assign pat = pattern_word(idx6);

endmodule

// File: rtl/mpt_ctrl.sv
module mpt_ctrl
  import mpt_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int NUM_WORDS = 64,
  parameter int IDX_W     = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [ADDR_W-1:0] base_addr,
  input  logic [IDX_W-1:0]  word_idx,
  input  logic              word_last,
  input  logic              rep_last,
  input  word_t             pat,
  output logic              word_clr,
  output logic              word_inc,
  output logic              rep_clr,
  output logic              rep_inc,
  output logic              done,
  output logic              pass,
  output logic [ADDR_W-1:0] mem_addr,
  output word_t             mem_wdata,
  output logic              mem_we,
  output logic              mem_re,
  input  word_t             mem_rdata,
  input  logic              mem_ack
);

  mpt_state_e        state;
  logic [ADDR_W-1:0] base_q;
  logic              accept;
  logic              wr_ack;
  logic              rd_ack;
  logic              rd_ok;

  assign accept = (state == ST_IDLE) && start;
  assign wr_ack = (state == ST_WR_WAIT) && mem_ack;
  assign rd_ack = (state == ST_RD_WAIT) && mem_ack;
  assign rd_ok  = rd_ack && (mem_rdata == pat);

  assign word_clr = accept;
  assign rep_clr  = accept;
  assign rep_inc  = rd_ok;
  assign word_inc = wr_ack || (rd_ok && rep_last);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      base_q    <= '0;
      done      <= 1'b0;
      pass      <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      mem_we    <= 1'b0;
      mem_re    <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start) begin
            base_q <= base_addr;
            pass   <= 1'b0;
            state  <= ST_WR_ISSUE;
          end
        end
        ST_WR_ISSUE: begin
          mem_we    <= 1'b1;
          mem_addr  <= base_q + ADDR_W'(word_idx);
          mem_wdata <= pat;
          state     <= ST_WR_WAIT;
        end
        ST_WR_WAIT: begin
          if (mem_ack) begin
            mem_we <= 1'b0;
            state  <= word_last ? ST_RD_ISSUE : ST_WR_ISSUE;
          end
        end
        ST_RD_ISSUE: begin
          mem_re   <= 1'b1;
          mem_addr <= base_q + ADDR_W'(word_idx);
          state    <= ST_RD_WAIT;
        end
        ST_RD_WAIT: begin
          if (mem_ack) begin
            mem_re <= 1'b0;
            if (mem_rdata != pat) begin
              done  <= 1'b1;
              pass  <= 1'b0;
              state <= ST_IDLE;
            end else if (word_last && rep_last) begin
              done  <= 1'b1;
              pass  <= 1'b1;
              state <= ST_IDLE;
            end else begin
              state <= ST_RD_ISSUE;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // Assertion support: write acknowledges seen in the current run
  localparam int ACNT_W = $clog2(NUM_WORDS + 1);
  logic [ACNT_W-1:0] wr_acks;

  always_ff @(posedge clk) begin
    if (rst || accept) begin
      wr_acks <= '0;
    end else if (mem_we && mem_ack) begin
      wr_acks <= wr_acks + ACNT_W'(1);
    end
  end

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    $past(rst) |-> !done && !pass && !mem_we && !mem_re);

  // R2
  reads_after_writes_chk: assert property (@(posedge clk) disable iff (rst)
    mem_re |-> (wr_acks == ACNT_W'(NUM_WORDS)));

  // R4
  single_req_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({mem_we, mem_re}));

  // R4
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_we || mem_re) && !mem_ack |=>
      $stable(mem_we) && $stable(mem_re) && $stable(mem_addr) && $stable(mem_wdata));

  // R4
  req_gap_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_we || mem_re) && mem_ack |=> !mem_we && !mem_re);

  // R6
  done_after_read_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(mem_re && mem_ack));

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R8
  pass_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (pass != $past(pass)) |-> (done || $past(start)));

  // R9
  busy_base_chk: assert property (@(posedge clk) disable iff (rst)
    (state != ST_IDLE) |=> $stable(base_q));

endmodule

// File: rtl/mem_pattern_checker.sv
module mem_pattern_checker
  import mpt_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int NUM_WORDS   = PAT_LEN,
  parameter int READ_REPEAT = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [ADDR_W-1:0] base_addr,
  output logic              done,
  output logic              pass,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [31:0]       mem_wdata,
  output logic              mem_we,
  output logic              mem_re,
  input  logic [31:0]       mem_rdata,
  input  logic              mem_ack
);

  localparam int IDX_W = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1;
  localparam int REP_W = (READ_REPEAT > 1) ? $clog2(READ_REPEAT) : 1;

  logic [IDX_W-1:0] word_idx;
  logic [REP_W-1:0] rep_idx;
  logic             word_last, rep_last;
  logic             word_clr, word_inc, rep_clr, rep_inc;
  word_t            pat;

  mpt_counter #(.LIMIT(NUM_WORDS)) u_word_cnt (
    .clk     (clk),
    .rst     (rst),
    .clr     (word_clr),
    .inc     (word_inc),
    .val     (word_idx),
    .at_last (word_last)
  );

  mpt_counter #(.LIMIT(READ_REPEAT)) u_rep_cnt (
    .clk     (clk),
    .rst     (rst),
    .clr     (rep_clr),
    .inc     (rep_inc),
    .val     (rep_idx),
    .at_last (rep_last)
  );

  mpt_pattern_gen #(.IDX_W(IDX_W)) u_pat (
    .idx (word_idx),
    .pat (pat)
  );

  mpt_ctrl #(
    .ADDR_W    (ADDR_W),
    .NUM_WORDS (NUM_WORDS),
    .IDX_W     (IDX_W)
  ) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .base_addr (base_addr),
    .word_idx  (word_idx),
    .word_last (word_last),
    .rep_last  (rep_last),
    .pat       (pat),
    .word_clr  (word_clr),
    .word_inc  (word_inc),
    .rep_clr   (rep_clr),
    .rep_inc   (rep_inc),
    .done      (done),
    .pass      (pass),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_we    (mem_we),
    .mem_re    (mem_re),
    .mem_rdata (mem_rdata),
    .mem_ack   (mem_ack)
  );

  // R5: repeat counter only advances while reading
  rep_idle_chk: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> (rep_idx == '0));

endmodule

// File: tb/tb_mem_pattern_checker.sv
`timescale 1ns/1ps
module tb_mem_pattern_checker;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [7:0]  base_addr = 8'd0;
  logic        done, pass;
  logic [7:0]  mem_addr;
  logic [31:0] mem_wdata;
  logic        mem_we, mem_re;
  logic [31:0] mem_rdata = 32'd0;
  logic        mem_ack = 1'b0;

  always #2.5 clk = ~clk;

  mem_pattern_checker #(.ADDR_W(8), .NUM_WORDS(64), .READ_REPEAT(10)) dut (
    .clk(clk), .rst(rst), .start(start), .base_addr(base_addr),
    .done(done), .pass(pass), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_we(mem_we), .mem_re(mem_re), .mem_rdata(mem_rdata), .mem_ack(mem_ack)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  int lat = 0, fault_rd = -1, stuck_word = -1;
  logic [31:0] fmask = 32'd1;
  logic [7:0]  run_base = 8'd0;
  int wr_cnt, rd_cnt, wa_err, wd_err, rd_err, hold_err, post_req, done_cnt, done_cyc, last_ack_cyc;
  logic done_pass;
  int wait_cnt = 0;
  bit in_txn = 0;
  logic [7:0]  cap_addr;
  logic [31:0] cap_data;
  logic [31:0] ram [256];

  function automatic logic [31:0] exp_pat(input int i);
    logic [31:0] g;
    logic [15:0] inv_map;
    inv_map = 16'h33CC;
    case ((i / 16) % 4)
      0: g = 32'h00000000;
      1: g = 32'hAAAAAAAA;
      2: g = 32'hA5A5A5A5;
      default: g = 32'hAA55AA55;
    endcase
    return inv_map[i % 16] ? ~g : g;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Behavioural memory with programmable latency and fault injection
  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      if (done) begin
        done_cnt++;
        done_cyc = cyc;
        done_pass = pass;
      end
      if (mem_ack) begin
        mem_ack = 1'b0;
      end else if (mem_we || mem_re) begin
        if (done_cnt > 0) post_req++;
        if (!in_txn) begin
          in_txn = 1; wait_cnt = 0; cap_addr = mem_addr; cap_data = mem_wdata;
        end else if (mem_addr != cap_addr || (mem_we && mem_wdata != cap_data)) begin
          hold_err++;
        end
        if (wait_cnt >= lat) begin
          mem_ack = 1'b1;
          in_txn = 0;
          last_ack_cyc = cyc;
          if (mem_we) begin
            if (rd_cnt != 0 || mem_addr != 8'(run_base + wr_cnt)) wa_err++;
            if (mem_wdata != exp_pat(wr_cnt)) wd_err++;
            ram[mem_addr] = (wr_cnt == stuck_word) ? (mem_wdata ^ fmask) : mem_wdata;
            wr_cnt++;
          end else begin
            if (wr_cnt != 64 || mem_addr != 8'(run_base + rd_cnt / 10)) rd_err++;
            mem_rdata = (rd_cnt == fault_rd) ? (ram[mem_addr] ^ fmask) : ram[mem_addr];
            rd_cnt++;
          end
        end else begin
          wait_cnt++;
        end
      end
    end
  end

  task automatic run(input logic [7:0] b, input int l, input int frd, input int sw,
                     input logic [31:0] m, input bit mid_start);
    int exp_rd;
    bit exp_pass;
    lat = l; fault_rd = frd; stuck_word = sw; fmask = m; run_base = b;
    wr_cnt = 0; rd_cnt = 0; wa_err = 0; wd_err = 0; rd_err = 0;
    hold_err = 0; post_req = 0; done_cnt = 0; done_cyc = 0; last_ack_cyc = 0;
    exp_pass = (frd < 0) && (sw < 0);
    exp_rd = (frd >= 0) ? frd + 1 : ((sw >= 0) ? sw * 10 + 1 : 640);
    @(negedge clk); base_addr = b; start = 1'b1;
    @(negedge clk); start = 1'b0; base_addr = ~b;
    chk(pass == 1'b0, "R8", "pass cleared after start", pass, 0);
    if (mid_start) begin
      while (wr_cnt < 20) @(negedge clk);
      base_addr = b + 8'd37; start = 1'b1;
      @(negedge clk); start = 1'b0;
    end
    while (done_cnt == 0) @(negedge clk);
    repeat (6) @(negedge clk);
    chk(done_pass == exp_pass, exp_pass ? "R7" : "R6", "pass at done", done_pass, exp_pass);
    chk(rd_cnt == exp_rd, exp_pass ? "R7" : "R6", "reads issued", rd_cnt, exp_rd);
    chk(wr_cnt == 64 && wa_err == 0, "R2", "write count/addr errors", wr_cnt * 1000 + wa_err, 64000);
    chk(wd_err == 0, "R3", "write data mismatches", wd_err, 0);
    chk(rd_err == 0, "R5", "read order/addr errors", rd_err, 0);
    chk(hold_err == 0, "R4", "request changed before ack", hold_err, 0);
    chk(post_req == 0, "R6", "requests after done", post_req, 0);
    chk(done_cnt == 1, mid_start ? "R9" : "R8", "done pulses", done_cnt, 1);
    chk(done_cyc == last_ack_cyc + 1, "R8", "done cycle after last ack", done_cyc, last_ack_cyc + 1);
    chk(pass == exp_pass, "R8", "pass held", pass, exp_pass);
    if (mid_start) chk(wa_err == 0 && rd_err == 0, "R10", "base kept despite input change", wa_err + rd_err, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 150000, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    chk(!done && !pass && !mem_we && !mem_re, "R1", "outputs in reset",
        {done, pass, mem_we, mem_re}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(!done && !pass && !mem_we && !mem_re, "R1", "outputs after reset",
        {done, pass, mem_we, mem_re}, 0);
    run(8'd0,   0, -1,  -1, 32'h0000_0001, 1'b0);
    run(8'd100, 2, -1,  -1, 32'h0000_0001, 1'b1);
    run(8'd250, 1, -1,  -1, 32'h0000_0001, 1'b0);
    run(8'd16,  0,  0,  -1, 32'h0000_0004, 1'b0);
    run(8'd40,  1, 639, -1, 32'h0100_0000, 1'b0);
    run(8'd64,  3, -1,  37, 32'h0001_0000, 1'b0);
    run(8'd8,   0, 455, -1, 32'h8000_0000, 1'b0);
    run(8'd5,   0, -1,  -1, 32'h0000_0001, 1'b0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule